// File: doc/BRIEF.md
# Multichannel PWM with Pair Joining

This block drives eight pulse-width-modulated pins. Each channel has its own 8-bit counter, a period value and a duty value. The counter advances only when a shared, already-prescaled tick input is high. Each channel can select its output polarity and can count in one of two ways. In edge mode the counter wraps from the top back to zero. In symmetric mode it climbs to the top and then descends back to zero.

Two neighbouring channels can be fused into a single 16-bit channel for finer resolution. The fused channel takes its control settings from the odd-numbered member and drives its pulse on that member's pin.

Software configures the block through a one-cycle write strobe that carries a kind code, a channel number and a data byte. Each channel also has its own enable input. Period and duty writes go to holding registers. The running channel adopts them only when its period starts over, so no pulse is ever cut short.

Top module: `pwm8_concat`

## Requirements
- R1: After reset every pin is low, every channel is active-high and in edge mode, all periods and duties are 0, and no pairs are fused.
- R2: In edge mode with period P, the counter runs 0..P-1 on ticks and then wraps. The pin is at its active level while the counter is below the duty D, so the period is P ticks.
- R3: In symmetric mode the counter runs 0..P-1 and then P-1..0, which is 2P ticks. The pin is active while the counter is below D.
- R4: Duty 0 keeps the pin inactive for the whole period. A duty greater than or equal to the period keeps it active for the whole period.
- R5: A period of 0 holds the pin at its inactive level.
- R6: Mode bit 0 = 1 makes the active level high. Bit 0 = 0 makes it low. The inactive level is always the opposite of the active level.
- R7: A disabled channel shows its inactive level. It holds its counter at the start of the period and keeps copying its held period and duty, so a newly enabled channel starts a fresh period with the latest values.
- R8: A period or duty write reaches the running channel only at the tick that restarts its period, or on the next clock while the channel is disabled.
- R9: Counters move only on clocks where tick is high. With tick low, no pin changes unless an enable or a register write changes.
- R10: Join bit k fuses channels 2k and 2k+1. The odd channel supplies the high byte of the 16-bit period and duty and also supplies the enable, polarity and mode. The pulse appears on pin 2k+1, and pin 2k stays at its own inactive level.
- R11: A join write that flips bit k restarts both counters of pair k and loads their held values. The four bits allow every mix from eight 8-bit channels to four 16-bit channels.
- R12: The write kind codes are 0 = period, 1 = duty, 2 = mode (bit 0 polarity, bit 1 symmetric), and 3 = join mask (bits 3:0). Kinds 0 to 2 target the channel in wr_ch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write kind: period, duty, mode or join mask |
| wr_ch | input | 3 | Target channel for kinds 0 to 2 |
| wr_data | input | 8 | Write data byte |
| ch_en | input | 8 | Per-channel run enable |
| pwm_out | output | 8 | PWM pins |

## Verification
On every cycle, the assertions check three things. The even pin of a fused pair stays steady. A disabled channel's pin stays frozen. A pin only moves after a tick, an enable change or a write. Whether each pulse has the right width and period in edge and symmetric modes, across fused and split pairs and buffered updates, can only be shown by the bench. Its behavioural model tracks each channel's position in its period and compares all pins on every clock.

// File: rtl/pwm8_concat.sv
module pwm8_concat #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_en,
  input  logic [1:0]             wr_kind,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [CW-1:0]          wr_data,
  input  logic [NCH-1:0]         ch_en,
  output logic [NCH-1:0]         pwm_out
);
  localparam int NP = NCH / 2;
  localparam int WW = 2 * CW;
  localparam int AW = $clog2(NCH);

  logic [NP-1:0] cat_q;
  wire cat_wr = wr_en && wr_kind == 2'd3;

  always_ff @(posedge clk)
    if (!rst_n)      cat_q <= '0;
    else if (cat_wr) cat_q <= wr_data[NP-1:0];

  // returns {restart, up, next count}
  function automatic logic [WW+1:0] step(input logic [WW-1:0] c, input logic u,
                                         input logic [WW-1:0] p, input logic ce);
    logic rs, nu;
    logic [WW-1:0] nc;
    rs = 1'b0; nu = u; nc = c;
    if (p == '0) begin
      rs = 1'b1; nc = '0; nu = 1'b1;
    end else if (!ce) begin
      nu = 1'b1;
      if (c >= p - 1'b1) begin rs = 1'b1; nc = '0; end
      else nc = c + 1'b1;
    end else if (u) begin
      if (c >= p - 1'b1) nu = 1'b0;
      else nc = c + 1'b1;
    end else begin
      if (c == '0) begin rs = 1'b1; nu = 1'b1; end
      else nc = c - 1'b1;
    end
    return {rs, nu, nc};
  endfunction

  for (genvar k = 0; k < NP; k++) begin : g_pair
    logic [CW-1:0] pb [2];
    logic [CW-1:0] db [2];
    logic [CW-1:0] pa [2];
    logic [CW-1:0] da [2];
    logic [CW-1:0] cnt [2];
    logic          up  [2];
    logic          pol [2];
    logic          cen [2];
    logic [WW+1:0] s8  [2];
    logic [WW+1:0] sw;
    logic          a0, a1;

    wire flip = cat_wr && (wr_data[k] != cat_q[k]);

    always_ff @(posedge clk)
      if (!rst_n) begin
        for (int j = 0; j < 2; j++) begin
          pb[j] <= '0; db[j] <= '0; pol[j] <= 1'b1; cen[j] <= 1'b0;
        end
      end else if (wr_en) begin
        for (int j = 0; j < 2; j++)
          if (wr_ch == AW'(2*k+j))
            case (wr_kind)
              2'd0: pb[j] <= wr_data;
              2'd1: db[j] <= wr_data;
              2'd2: begin pol[j] <= wr_data[0]; cen[j] <= wr_data[1]; end
              default: ;
            endcase
      end

    assign s8[0] = step({{CW{1'b0}}, cnt[0]}, up[0], {{CW{1'b0}}, pa[0]}, cen[0]);
    assign s8[1] = step({{CW{1'b0}}, cnt[1]}, up[1], {{CW{1'b0}}, pa[1]}, cen[1]);
    assign sw    = step({cnt[1], cnt[0]}, up[1], {pa[1], pa[0]}, cen[1]);
    wire unused_hi = ^{s8[0][WW-1:CW], s8[1][WW-1:CW]};

    always_ff @(posedge clk)
      if (!rst_n) begin
        for (int j = 0; j < 2; j++) begin
          cnt[j] <= '0; up[j] <= 1'b1; pa[j] <= '0; da[j] <= '0;
        end
      end else if (flip || (cat_q[k] && !ch_en[2*k+1])) begin
        for (int j = 0; j < 2; j++) begin
          cnt[j] <= '0; up[j] <= 1'b1; pa[j] <= pb[j]; da[j] <= db[j];
        end
      end else if (cat_q[k]) begin
        if (tick) begin
          {cnt[1], cnt[0]} <= sw[WW-1:0];
          up[1] <= sw[WW];
          up[0] <= 1'b1;
          if (sw[WW+1])
            for (int j = 0; j < 2; j++) begin pa[j] <= pb[j]; da[j] <= db[j]; end
        end
      end else begin
        for (int j = 0; j < 2; j++)
          if (!ch_en[2*k+j]) begin
            cnt[j] <= '0; up[j] <= 1'b1; pa[j] <= pb[j]; da[j] <= db[j];
          end else if (tick) begin
            cnt[j] <= s8[j][CW-1:0];
            up[j]  <= s8[j][WW];
            if (s8[j][WW+1]) begin pa[j] <= pb[j]; da[j] <= db[j]; end
          end
      end

    assign a0 = !cat_q[k] && ch_en[2*k] && pa[0] != '0 && cnt[0] < da[0];
    assign a1 = cat_q[k]
              ? (ch_en[2*k+1] && {pa[1], pa[0]} != '0 && {cnt[1], cnt[0]} < {da[1], da[0]})
              : (ch_en[2*k+1] && pa[1] != '0 && cnt[1] < da[1]);
    assign pwm_out[2*k]   = pol[0] ? a0 : ~a0;
    assign pwm_out[2*k+1] = pol[1] ? a1 : ~a1;
  end
endmodule

module pwm8_concat_chk #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            wr_en,
  input logic [1:0]      wr_kind,
  input logic [CW-1:0]   wr_data,
  input logic [NCH-1:0]  ch_en,
  input logic [NCH-1:0]  pwm_out,
  input logic [NCH/2-1:0] cat_q
);
  localparam int NP = NCH / 2;
  wire mode_wr = wr_en && wr_kind == 2'd2;

  // R9
  out_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_out) |-> ($past(tick) || !$stable(ch_en) || $past(wr_en)));

  // R11
  cat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd3) |=> cat_q == $past(wr_data[NP-1:0]));

  for (genvar k = 0; k < NP; k++) begin : g_pair_chk
    // R10
    lo_pin_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_q[k] && $past(cat_q[k]) && !$past(mode_wr)) |-> $stable(pwm_out[2*k]));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
    // R7
    idle_pin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[c] && $past(!ch_en[c]) && !$past(mode_wr) && $stable(cat_q))
        |-> $stable(pwm_out[c]));
  end
endmodule

bind pwm8_concat pwm8_concat_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_data(wr_data), .ch_en(ch_en), .pwm_out(pwm_out), .cat_q(cat_q)
);

// File: tb/sim_pwm8_concat.sv
module sim_pwm8_concat;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [2:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ch_en = '0;
  logic [7:0] pwm_out;

  int n_chk = 0, n_err = 0;
  int tick_div = 1, tcnt = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  int pb[8], db[8], pa[8], da[8], pos[8];
  bit pol[8], cen[8];
  bit [3:0] mcat;

  pwm8_concat u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_kind(wr_kind),
                  .wr_ch(wr_ch), .wr_data(wr_data), .ch_en(ch_en), .pwm_out(pwm_out));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    tick <= (tcnt + 1 >= tick_div);
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ld(input int c);
    pa[c] = pb[c]; da[c] = db[c];
  endtask

  function automatic bit act_at(input int p, input int d, input int ps, input bit ce, input bit en);
    int cv;
    cv = (!ce || ps < p) ? ps : 2*p - 1 - ps;
    return en && p != 0 && cv < d;
  endfunction

  function automatic logic [7:0] model_out();
    logic [7:0] o;
    for (int k = 0; k < 4; k++) begin
      int lo, hi;
      bit a;
      lo = 2*k; hi = lo + 1;
      if (mcat[k]) begin
        a = act_at(pa[hi]*256 + pa[lo], da[hi]*256 + da[lo], pos[hi], cen[hi], ch_en[hi]);
        o[hi] = pol[hi] ? a : !a;
        o[lo] = !pol[lo];
      end else begin
        for (int j = 0; j < 2; j++) begin
          a = act_at(pa[lo+j], da[lo+j], pos[lo+j], cen[lo+j], ch_en[lo+j]);
          o[lo+j] = pol[lo+j] ? a : !a;
        end
      end
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin
        pb[c] = 0; db[c] = 0; pa[c] = 0; da[c] = 0; pos[c] = 0; pol[c] = 1; cen[c] = 0;
      end
      mcat = '0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        int lo, hi, len;
        lo = 2*k; hi = lo + 1;
        if (wr_en && wr_kind == 2'd3 && wr_data[k] != mcat[k]) begin
          pos[lo] = 0; pos[hi] = 0; ld(lo); ld(hi);
        end else if (mcat[k]) begin
          if (!ch_en[hi]) begin
            pos[lo] = 0; pos[hi] = 0; ld(lo); ld(hi);
          end else if (tick) begin
            len = (pa[hi]*256 + pa[lo]) * (cen[hi] ? 2 : 1);
            pos[hi]++;
            if (pos[hi] >= len) begin pos[hi] = 0; ld(lo); ld(hi); end
          end
        end else begin
          for (int j = 0; j < 2; j++) begin
            int c;
            c = lo + j;
            if (!ch_en[c]) begin
              pos[c] = 0; ld(c);
            end else if (tick) begin
              len = pa[c] * (cen[c] ? 2 : 1);
              pos[c]++;
              if (pos[c] >= len) begin pos[c] = 0; ld(c); end
            end
          end
        end
      end
      if (wr_en)
        case (wr_kind)
          2'd0: pb[wr_ch] = wr_data;
          2'd1: db[wr_ch] = wr_data;
          2'd2: begin pol[wr_ch] = wr_data[0]; cen[wr_ch] = wr_data[1]; end
          default: mcat = wr_data[3:0];
        endcase
    end
  end

  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && cmp_on) check(cur_req, pwm_out, model_out());
  end

  task automatic wr(input logic [1:0] kd, input int ch, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kd; wr_ch = ch[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int pin, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[pin]) hi++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check("R1 reset pins low", pwm_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", pwm_out, 8'h00);
    cmp_on = 1'b1;

    cur_req = "R12";
    wr(2'd0, 0, 5); wr(2'd1, 0, 2);
    wr(2'd0, 1, 4); wr(2'd1, 1, 0);
    wr(2'd0, 2, 3); wr(2'd1, 2, 3);
    wr(2'd0, 3, 6); wr(2'd1, 3, 9);
    wr(2'd0, 4, 4); wr(2'd1, 4, 1); wr(2'd2, 4, 8'h03);
    wr(2'd0, 5, 0); wr(2'd1, 5, 2);
    wr(2'd0, 6, 7); wr(2'd1, 6, 3); wr(2'd2, 6, 8'h00);
    wr(2'd0, 7, 1); wr(2'd1, 7, 1); wr(2'd2, 7, 8'h03);
    @(negedge clk);
    check("R6 R7 disabled inactive levels", pwm_out, 8'h40);

    cur_req = "R2";
    @(negedge clk); ch_en = 8'hFF;
    count_high(0, 120, h); check("R2 edge P5 D2 highs", 8'(h), 8'd48);
    count_high(1, 120, h); check("R4 duty 0 highs", 8'(h), 8'd0);
    count_high(2, 120, h); check("R4 duty=period highs", 8'(h), 8'd120);
    count_high(3, 120, h); check("R4 duty>period highs", 8'(h), 8'd120);
    count_high(4, 120, h); check("R3 symmetric P4 D1 highs", 8'(h), 8'd30);
    count_high(5, 120, h); check("R5 period 0 highs", 8'(h), 8'd0);
    count_high(7, 120, h); check("R3 symmetric P1 D1 highs", 8'(h), 8'd120);

    cur_req = "R8";
    wr(2'd1, 0, 4); wr(2'd0, 0, 8);
    repeat (40) @(negedge clk);
    wr(2'd1, 6, 6);
    repeat (40) @(negedge clk);

    cur_req = "R9";
    tick_div = 1000;
    repeat (3) @(negedge clk);
    begin
      logic [7:0] snap;
      snap = pwm_out;
      repeat (20) @(negedge clk);
      check("R9 no tick pins frozen", pwm_out, snap);
    end
    tick_div = 3;
    repeat (90) @(negedge clk);
    tick_div = 1;

    cur_req = "R12";
    wr(2'd2, 2, 8'h00);
    @(negedge clk);
    check("R6 R12 flipped polarity ch2", {7'd0, pwm_out[2]}, 8'd0);

    cur_req = "R10";
    @(negedge clk); ch_en = 8'h00;
    wr(2'd0, 0, 8'h02); wr(2'd0, 1, 8'h01); wr(2'd1, 0, 8'h80); wr(2'd1, 1, 8'h00);
    wr(2'd2, 1, 8'h01);
    wr(2'd0, 4, 8'h03); wr(2'd0, 5, 8'h00); wr(2'd1, 4, 8'h01); wr(2'd1, 5, 8'h00);
    wr(2'd2, 5, 8'h03);
    wr(2'd3, 0, 8'h05);
    @(negedge clk); ch_en = 8'hFF;
    count_high(1, 258, h); check("R10 fused P258 D128 highs", 8'(h/2), 8'd64);
    count_high(5, 258, h); check("R10 fused symmetric P3 D1 highs", 8'(h), 8'd86);
    count_high(0, 100, h); check("R10 even pin held pair0", 8'(h), 8'd0);
    count_high(4, 100, h); check("R10 even pin held pair2", 8'(h), 8'd0);

    cur_req = "R11";
    wr(2'd3, 0, 8'h0F); repeat (60) @(negedge clk);
    wr(2'd3, 0, 8'h0A); repeat (60) @(negedge clk);
    wr(2'd3, 0, 8'h00); repeat (60) @(negedge clk);

    cur_req = "R7";
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      ch_en = 8'($urandom);
      wr(2'(($urandom % 2)), $urandom % 8, 8'($urandom % 12));
      if (i % 20 == 0) wr(2'd3, 0, 8'($urandom % 16));
      repeat ($urandom % 15) @(negedge clk);
    end
    @(negedge clk); ch_en = 8'h00; wr(2'd3, 0, 8'h00);
    @(negedge clk);
    begin
      logic [7:0] inact;
      for (int c = 0; c < 8; c++) inact[c] = !pol[c];
      check("R7 all disabled inactive", pwm_out, inact);
    end

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule